// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block owns the instruction address register of a fetch stage for 32-bit fixed-length instructions. Every clock it chooses the address of the next instruction to fetch: the following sequential word, a PC-relative conditional branch destination, or an absolute jump destination. The chosen address is registered and presented as the current program counter.

Conditional branches compare two register operands and test only for equality or inequality. A less-than branch is built in software from a set-less-than result that is then compared against zero with the not-equal kind. The branch displacement is a signed 16-bit word count relative to the instruction after the branch. It is sign-extended, scaled to bytes, and added to the incremented PC. Instruction memory and the formation of the jump target field lie outside the block, and it receives the jump destination as a full address.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset, active high on `rst`, sets `pc_q` to 0x00000000 at the next rising clock edge.
- R2: When neither `br_en` nor `jmp_en` is high, `pc_q` increases by 4 at each rising edge, modulo 2^32.
- R3: With `br_en` high and `br_kind` = 0 (equal), the branch is taken when `opnd_a` equals `opnd_b`. Then `pc_q` becomes old `pc_q` + 4 + (sign-extended `br_off` × 4).
- R4: With `br_en` high and `br_kind` = 1 (not equal), the branch is taken when `opnd_a` differs from `opnd_b`, and `pc_q` is loaded with the same target as in R3.
- R5: A conditional branch that is not taken advances `pc_q` by 4, exactly as in R2.
- R6: With `jmp_en` high, `pc_q` is loaded with `jmp_tgt`, and bits [1:0] of the loaded value are forced to zero.
- R7: When `jmp_en` and `br_en` are both high, the jump wins, whatever the branch outcome would be.
- R8: The branch displacement covers -32768 to +32767 words from the instruction after the branch (bit 15 of `br_off` is the sign). Target arithmetic wraps modulo 2^32.
- R9: Bits [1:0] of `pc_q` are zero in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| br_en | input | 1 | Current instruction is a conditional branch |
| br_kind | input | 1 | 0 = branch on equal, 1 = branch on not equal |
| br_off | input | 16 | Signed branch displacement in words |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| jmp_en | input | 1 | Current instruction is an unconditional jump |
| jmp_tgt | input | 32 | Absolute jump destination (low two bits ignored) |
| pc_q | output | 32 | Current program counter |

## Verification
The hardest cases to reach are the extremes of the displacement and the address wrap. A branch of -32768 words must be taken from a PC small enough that the sum passes below zero, and a branch of +32767 words must be taken near the top of the address space so that it wraps upward. The stimulus first loads a chosen PC with a jump. It then issues taken branches of both kinds with the extreme displacements. It also drives operand pairs that differ in only the top or only the bottom bit, so that the equal and not-equal decisions are tested on minimal differences. The jump-versus-branch conflict is driven with both a taken and a not-taken branch condition underneath.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic {
      BR_EQ = 1'b0,
      BR_NE = 1'b1
   } br_kind_e;

   typedef enum logic [1:0] {
      SEL_SEQ    = 2'd0,
      SEL_BRANCH = 2'd1,
      SEL_JUMP   = 2'd2
   } npc_sel_e;
endpackage

// File: rtl/npc_seq_inc.sv
module npc_seq_inc #(
   parameter int ADDR_W     = 32,
   parameter int INSTR_BYTES = 4
) (
   input  logic [ADDR_W-1:0] pc_cur,
   output logic [ADDR_W-1:0] pc_plus
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

   always_comb begin
      pc_plus = pc_cur + STEP;
   end
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp #(
   parameter int DATA_W    = 32,
   parameter int CMP_STYLE = 0
) (
   input  logic              kind,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic              cond_ok
);
   import npc_pkg::*;

   logic same;

   generate
      if (CMP_STYLE == 0) begin : g_direct
         always_comb begin
            same = (lhs == rhs);
         end
      end else begin : g_xor
         logic [DATA_W-1:0] diff_bits;
         always_comb begin
            diff_bits = lhs ^ rhs;
            same      = ~(|diff_bits);
         end
      end
   endgenerate

   always_comb begin
      unique case (br_kind_e'(kind))
         BR_EQ:   cond_ok = same;
         BR_NE:   cond_ok = ~same;
         default: cond_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_tgt.sv
module npc_tgt #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int SCALE  = 2
) (
   input  logic [ADDR_W-1:0] pc_plus,
   input  logic [OFF_W-1:0]  off_words,
   output logic [ADDR_W-1:0] tgt
);
   localparam int EXT_W = ADDR_W - OFF_W - SCALE;

   logic [ADDR_W-1:0] off_bytes;

   generate
      if (EXT_W > 0) begin : g_ext
         always_comb begin
            off_bytes = {{EXT_W{off_words[OFF_W-1]}}, off_words, {SCALE{1'b0}}};
         end
      end else begin : g_noext
         always_comb begin
            off_bytes = {off_words, {SCALE{1'b0}}};
         end
      end
   endgenerate

   always_comb begin
      tgt = pc_plus + off_bytes;
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int              ADDR_W      = 32,
   parameter int              OFF_W       = 16,
   parameter int              INSTR_BYTES = 4,
   parameter int              CMP_STYLE   = 0,
   parameter logic [31:0]     RESET_PC    = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              br_en,
   input  logic              br_kind,
   input  logic [OFF_W-1:0]  br_off,
   input  logic [ADDR_W-1:0] opnd_a,
   input  logic [ADDR_W-1:0] opnd_b,
   input  logic              jmp_en,
   input  logic [ADDR_W-1:0] jmp_tgt,
   output logic [ADDR_W-1:0] pc_q
);
   import npc_pkg::*;

   localparam int              SCALE      = $clog2(INSTR_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(INSTR_BYTES - 1);
   localparam logic [ADDR_W-1:0] RST_VAL    = ADDR_W'(RESET_PC);

   if (ADDR_W < OFF_W + SCALE) begin : g_bad_width
      $error("npc_unit: ADDR_W too small for scaled offset");
   end
   if ((1 << SCALE) != INSTR_BYTES) begin : g_bad_bytes
      $error("npc_unit: INSTR_BYTES must be a power of two");
   end
   if ((RST_VAL & ALIGN_MASK) != '0) begin : g_bad_reset
      $error("npc_unit: RESET_PC must be aligned");
   end

   logic [ADDR_W-1:0] pc_plus;
   logic [ADDR_W-1:0] br_tgt;
   logic [ADDR_W-1:0] jmp_aligned;
   logic [ADDR_W-1:0] pc_next;
   logic              cond_ok;
   npc_sel_e          sel;

   npc_seq_inc #(
      .ADDR_W      (ADDR_W),
      .INSTR_BYTES (INSTR_BYTES)
   ) inc_i (
      .pc_cur  (pc_q),
      .pc_plus (pc_plus)
   );

   npc_cmp #(
      .DATA_W    (ADDR_W),
      .CMP_STYLE (CMP_STYLE)
   ) cmp_i (
      .kind    (br_kind),
      .lhs     (opnd_a),
      .rhs     (opnd_b),
      .cond_ok (cond_ok)
   );

   npc_tgt #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .SCALE  (SCALE)
   ) tgt_i (
      .pc_plus   (pc_plus),
      .off_words (br_off),
      .tgt       (br_tgt)
   );

   always_comb begin
      jmp_aligned = jmp_tgt & ~ALIGN_MASK;
      if (jmp_en) begin
         sel = SEL_JUMP;
      end else if (br_en && cond_ok) begin
         sel = SEL_BRANCH;
      end else begin
         sel = SEL_SEQ;
      end
      unique case (sel)
         SEL_JUMP:   pc_next = jmp_aligned;
         SEL_BRANCH: pc_next = br_tgt;
         default:    pc_next = pc_plus;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= RST_VAL;
      end else begin
         pc_q <= pc_next;
      end
   end

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
      (!br_en && !jmp_en) |=> (pc_q == $past(pc_q) + ADDR_W'(INSTR_BYTES)));

   assert_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
      (br_en && !jmp_en && !cond_ok) |=> (pc_q == $past(pc_q) + ADDR_W'(INSTR_BYTES)));

   assert_jump_load_R6: assert property (@(posedge clk) disable iff (rst)
      jmp_en |=> (pc_q == ($past(jmp_tgt) & ~ALIGN_MASK)));

   assert_jump_wins_R7: assert property (@(posedge clk) disable iff (rst)
      (jmp_en && br_en && cond_ok) |=> (pc_q != $past(br_tgt) || $past(br_tgt) == $past(jmp_aligned)));

   assert_aligned_R9: assert property (@(posedge clk) disable iff (rst)
      ((pc_q & ALIGN_MASK) == '0));
endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        br_en = 1'b0;
   logic        br_kind = 1'b0;
   logic [15:0] br_off = '0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        jmp_en = 1'b0;
   logic [31:0] jmp_tgt = '0;
   logic [31:0] pc_q;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [31:0] model_pc = '0;

   always #5 clk = ~clk;

   npc_unit dut_i (
      .clk     (clk),
      .rst     (rst),
      .br_en   (br_en),
      .br_kind (br_kind),
      .br_off  (br_off),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b),
      .jmp_en  (jmp_en),
      .jmp_tgt (jmp_tgt),
      .pc_q    (pc_q)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<=5000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req);
      total = total + 1;
      if (pc_q !== model_pc) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", req, pc_q, model_pc);
      end
   endtask

   // Drive one cycle at the falling edge, advance the model at the rising
   // edge, compare at the next falling edge.
   task automatic step(input logic b, input logic k, input logic [15:0] off,
                       input logic [31:0] a, input logic [31:0] bb,
                       input logic j, input logic [31:0] t, input string req);
      logic take;
      logic [31:0] disp;
      br_en = b; br_kind = k; br_off = off;
      opnd_a = a; opnd_b = bb; jmp_en = j; jmp_tgt = t;
      @(posedge clk);
      take = b && (k ? (a != bb) : (a == bb));
      disp = {{14{off[15]}}, off, 2'b00};
      if (rst) model_pc = 32'h0;
      else if (j) model_pc = {t[31:2], 2'b00};
      else if (take) model_pc = model_pc + 32'd4 + disp;
      else model_pc = model_pc + 32'd4;
      @(negedge clk);
      check(req);
   endtask

   initial begin
      @(negedge clk);
      step(0, 0, 16'h0, 0, 0, 0, 0, "R1 reset");
      rst = 1'b0;
      for (int i = 0; i < 3; i++) step(0, 0, 16'h0, 0, 0, 0, 0, "R2 sequential");
      // beq equal, forward 8 words
      step(1, 0, 16'd8, 32'h1234_5678, 32'h1234_5678, 0, 0, "R3 beq taken");
      // beq differing only in bit 31 -> not taken
      step(1, 0, 16'd8, 32'h8000_0000, 32'h0, 0, 0, "R5 beq not taken");
      // bne differing only in bit 0 -> taken, backward 3 words
      step(1, 1, 16'hFFFD, 32'h1, 32'h0, 0, 0, "R4 bne taken");
      step(1, 1, 16'd100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 0, "R5 bne not taken");
      // less-than idiom: slt result 1 compared against zero
      step(1, 1, 16'd2, 32'h1, 32'h0, 0, 0, "R4 slt-based branch");
      // jump with unaligned target
      step(0, 0, 16'h0, 0, 0, 1, 32'h0000_0103, "R6 jump aligned");
      step(0, 0, 16'h0, 0, 0, 0, 0, "R9 low bits zero");
      // extreme negative offset wraps below zero
      step(1, 0, 16'h8000, 32'h5, 32'h5, 0, 0, "R8 min offset wrap");
      // set PC near top, then max positive offset wraps upward
      step(0, 0, 16'h0, 0, 0, 1, 32'hFFFF_FFF0, "R6 jump high");
      step(1, 1, 16'h7FFF, 32'h0, 32'h2, 0, 0, "R8 max offset wrap");
      // jump beats taken branch and not-taken branch
      step(1, 0, 16'd50, 32'h7, 32'h7, 1, 32'h0000_4000, "R7 jump over taken");
      step(1, 0, 16'd50, 32'h7, 32'h8, 1, 32'h0000_8002, "R7 jump over not-taken");
      step(0, 0, 16'h0, 0, 0, 0, 0, "R2 after jump");
      // sequential wrap at top of address space
      step(0, 0, 16'h0, 0, 0, 1, 32'hFFFF_FFFC, "R6 jump top");
      step(0, 0, 16'h0, 0, 0, 0, 0, "R2 wrap to zero");
      // mid-run reset with a jump pending
      rst = 1'b1;
      step(0, 0, 16'h0, 0, 0, 1, 32'h0000_1000, "R1 reset beats jump");
      rst = 1'b0;
      step(0, 0, 16'h0, 0, 0, 0, 0, "R2 after reset");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule